// File: doc/BRIEF.md
# Free-Running 64-bit Counter with Auto-Advancing Compare Channel

This block is a register-mapped system timer. Its core is a 64-bit up-counter that advances by one every clock cycle while its run bit is set. Software sees and loads it as two 32-bit words. A single 64-bit compare channel watches the counter; on an exact match it sets a sticky interrupt status bit, and the interrupt pin is that status gated by an enable bit.

In periodic mode the compare value adds a programmed increment to itself on every match, so events recur with no software action. A one-shot event is the same channel with the auto-advance bit clear. Software reads the full count as high, low, high and retries if the two high words differ, because the two halves are not captured together.

Every bus write is applied a fixed number of cycles after it is issued, modelling the crossing into a slower timer clock. On the cycle a tracked register takes the new value, a write-applied flag sets for it. Software polls the flag and clears it by writing 1.

Top module: `gct_top`

## Requirements
- R1: While the control run bit (bit 8 of 0x240) is 1 the counter increases by exactly one per clock cycle. While it is 0 the counter holds its value.
- R2: The counter reads and loads as a low word at 0x100 and a high word at 0x104. Each load replaces only its own half. A carry out of the low word increments the high word.
- R3: A bus write changes its target register exactly APPLY_LAT cycles after the write is accepted. A read issued in the cycle after the write still returns the old state.
- R4: Write-applied flags set on the apply cycle. At 0x24C, bit 0 is compare-low, bit 1 is compare-high, bit 2 is increment and bit 16 is control. At 0x110, bit 0 is counter-low and bit 1 is counter-high. Writing 1 to a flag clears it; writing 0 leaves it unchanged.
- R5: The compare words at 0x200 (low) and 0x204 (high) and the increment at 0x208 read back the last value written. The control register reads back bits 8, 1 and 0 only. The interrupt enable at 0x248 reads back bit 0.
- R6: When compare enable (bit 0 of 0x240) is 1 and the 64-bit counter equals the 64-bit compare value, status bit 0 of 0x244 sets. It stays set until software writes 1 to that bit.
- R7: With compare enable at 0, the status bit never sets, even when the counter passes the compare value.
- R8: With auto-advance (bit 1 of 0x240) set, each match adds the increment to the compare value. With it clear, the compare value is unchanged by a match.
- R9: The irq output is a registered copy of the status bit ANDed with enable bit 0 of 0x248.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Compare interrupt, active high |

## Verification
The following properties are checked on every cycle:
- the counter steps by one or holds according to the run bit;
- the status bit stays set until cleared and only rises after an enabled match;
- the compare value advances by the increment on an auto-advance match;
- irq never asserts without both status and enable.

Only the bench scenarios can show:
- the exact apply latency seen through the bus;
- the write-applied flags;
- readback of each register;
- the carry from the low word into the high word;
- the compare value left behind after a run of periodic matches.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] A_CNT_LO = 12'h100;
  localparam logic [BUS_AW-1:0] A_CNT_HI = 12'h104;
  localparam logic [BUS_AW-1:0] A_CNT_WS = 12'h110;
  localparam logic [BUS_AW-1:0] A_CMP_LO = 12'h200;
  localparam logic [BUS_AW-1:0] A_CMP_HI = 12'h204;
  localparam logic [BUS_AW-1:0] A_INCR   = 12'h208;
  localparam logic [BUS_AW-1:0] A_CTRL   = 12'h240;
  localparam logic [BUS_AW-1:0] A_ISTAT  = 12'h244;
  localparam logic [BUS_AW-1:0] A_IEN    = 12'h248;
  localparam logic [BUS_AW-1:0] A_WS     = 12'h24C;

  localparam int CTRL_RUN  = 8;
  localparam int CTRL_AUTO = 1;
  localparam int CTRL_CEN  = 0;

  localparam int WS_CMPLO = 0;
  localparam int WS_CMPHI = 1;
  localparam int WS_INCR  = 2;
  localparam int WS_CTRL  = 16;

  typedef struct packed {
    logic              vld;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/gct_wdelay.sv
module gct_wdelay
  import gct_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  wr_req_t d,
  output wr_req_t q
);
  for (genvar i = 0; i < LAT; i++) begin : g_stg
    wr_req_t r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[LAT-1].r;
endmodule

// File: rtl/gct_counter.sv
module gct_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (ld_lo) cnt <= {cnt[CNT_W-1:HALF_W], ld_data};
    else if (ld_hi) cnt <= {ld_data, cnt[HALF_W-1:0]};
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gct_compare.sv
module gct_compare #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cen,
  input  logic              auto_adv,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_incr,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic [HALF_W-1:0] incr,
  output logic              match
);
  assign match = cen && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)                    cmp <= '0;
    else if (wr_lo)             cmp <= {cmp[CNT_W-1:HALF_W], wdata};
    else if (wr_hi)             cmp <= {wdata, cmp[HALF_W-1:0]};
    else if (match && auto_adv) cmp <= cmp + CNT_W'(incr);
  end

  always_ff @(posedge clk) begin
    if (rst)          incr <= '0;
    else if (wr_incr) incr <= wdata;
  end
endmodule

// File: rtl/gct_top.sv
module gct_top
  import gct_pkg::*;
#(
  parameter int APPLY_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [BUS_DW-1:0] wr_data,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic [BUS_DW-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_DW;

  wr_req_t req_in, ap;
  assign req_in = '{vld: wr_en, addr: wr_addr, data: wr_data};

  gct_wdelay #(.LAT(APPLY_LAT)) u_dly (.clk(clk), .rst(rst), .d(req_in), .q(ap));

  logic hit_cnt_lo, hit_cnt_hi, hit_cnt_ws, hit_cmp_lo, hit_cmp_hi;
  logic hit_incr, hit_ctrl, hit_istat, hit_ien, hit_ws;
  always_comb begin
    hit_cnt_lo = ap.vld && (ap.addr == A_CNT_LO);
    hit_cnt_hi = ap.vld && (ap.addr == A_CNT_HI);
    hit_cnt_ws = ap.vld && (ap.addr == A_CNT_WS);
    hit_cmp_lo = ap.vld && (ap.addr == A_CMP_LO);
    hit_cmp_hi = ap.vld && (ap.addr == A_CMP_HI);
    hit_incr   = ap.vld && (ap.addr == A_INCR);
    hit_ctrl   = ap.vld && (ap.addr == A_CTRL);
    hit_istat  = ap.vld && (ap.addr == A_ISTAT);
    hit_ien    = ap.vld && (ap.addr == A_IEN);
    hit_ws     = ap.vld && (ap.addr == A_WS);
  end

  logic run_q, auto_q, cen_q, ien_q, istat_q;
  logic [1:0] cnt_ws_q;
  logic [3:0] gws_q;
  logic [CNT_W-1:0]  cnt_q, cmp_q;
  logic [BUS_DW-1:0] incr_q;
  logic match;

  gct_counter #(.HALF_W(BUS_DW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .ld_lo(hit_cnt_lo), .ld_hi(hit_cnt_hi),
    .ld_data(ap.data), .cnt(cnt_q)
  );

  gct_compare #(.HALF_W(BUS_DW)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt_q), .cen(cen_q), .auto_adv(auto_q),
    .wr_lo(hit_cmp_lo), .wr_hi(hit_cmp_hi), .wr_incr(hit_incr), .wdata(ap.data),
    .cmp(cmp_q), .incr(incr_q), .match(match)
  );

  logic       istat_n, ien_n;
  logic [1:0] cnt_ws_n;
  logic [3:0] gws_n, gws_clr;
  always_comb begin
    ien_n    = hit_ien ? ap.data[0] : ien_q;
    istat_n  = (istat_q && !(hit_istat && ap.data[0])) || match;
    cnt_ws_n = (cnt_ws_q & ~(hit_cnt_ws ? ap.data[1:0] : 2'b00)) | {hit_cnt_hi, hit_cnt_lo};
    gws_clr  = hit_ws ? {ap.data[WS_CTRL], ap.data[WS_INCR], ap.data[WS_CMPHI], ap.data[WS_CMPLO]}
                      : 4'b0000;
    gws_n    = (gws_q & ~gws_clr) | {hit_ctrl, hit_incr, hit_cmp_hi, hit_cmp_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      auto_q   <= 1'b0;
      cen_q    <= 1'b0;
      ien_q    <= 1'b0;
      istat_q  <= 1'b0;
      cnt_ws_q <= '0;
      gws_q    <= '0;
      irq      <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        run_q  <= ap.data[CTRL_RUN];
        auto_q <= ap.data[CTRL_AUTO];
        cen_q  <= ap.data[CTRL_CEN];
      end
      ien_q    <= ien_n;
      istat_q  <= istat_n;
      cnt_ws_q <= cnt_ws_n;
      gws_q    <= gws_n;
      irq      <= istat_n && ien_n;
    end
  end

  logic [BUS_DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CNT_LO: rd_mux = cnt_q[BUS_DW-1:0];
      A_CNT_HI: rd_mux = cnt_q[CNT_W-1:BUS_DW];
      A_CNT_WS: rd_mux[1:0] = cnt_ws_q;
      A_CMP_LO: rd_mux = cmp_q[BUS_DW-1:0];
      A_CMP_HI: rd_mux = cmp_q[CNT_W-1:BUS_DW];
      A_INCR:   rd_mux = incr_q;
      A_CTRL: begin
        rd_mux[CTRL_RUN]  = run_q;
        rd_mux[CTRL_AUTO] = auto_q;
        rd_mux[CTRL_CEN]  = cen_q;
      end
      A_ISTAT:  rd_mux[0] = istat_q;
      A_IEN:    rd_mux[0] = ien_q;
      A_WS: begin
        rd_mux[WS_CMPLO] = gws_q[0];
        rd_mux[WS_CMPHI] = gws_q[1];
        rd_mux[WS_INCR]  = gws_q[2];
        rd_mux[WS_CTRL]  = gws_q[3];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/gct_chk.sv
module gct_chk
  import gct_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ap_vld,
  input logic [BUS_AW-1:0] ap_addr,
  input logic [BUS_DW-1:0] ap_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [BUS_DW-1:0] incr_q,
  input logic              run_q,
  input logic              auto_q,
  input logic              cen_q,
  input logic              istat_q,
  input logic              ien_q,
  input logic              irq
);
  logic ld_any, clr_stat, cmp_wr;
  assign ld_any   = ap_vld && (ap_addr == A_CNT_LO || ap_addr == A_CNT_HI);
  assign clr_stat = ap_vld && (ap_addr == A_ISTAT) && ap_data[0];
  assign cmp_wr   = ap_vld && (ap_addr == A_CMP_LO || ap_addr == A_CMP_HI);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ld_any) |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ld_any) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (istat_q && !clr_stat) |=> istat_q); // R6
  AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(istat_q) |-> $past(cen_q && (cnt_q == cmp_q))); // R7
  AST_AUTO_ADV: assert property (@(posedge clk) disable iff (rst)
    (cen_q && auto_q && (cnt_q == cmp_q) && !cmp_wr)
      |=> (cmp_q == $past(cmp_q) + CNT_W'($past(incr_q)))); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (istat_q && ien_q)); // R9
endmodule

bind gct_top gct_chk #(.CNT_W(2 * gct_pkg::BUS_DW)) u_chk (
  .clk(clk), .rst(rst), .ap_vld(ap.vld), .ap_addr(ap.addr), .ap_data(ap.data),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .incr_q(incr_q), .run_q(run_q), .auto_q(auto_q),
  .cen_q(cen_q), .istat_q(istat_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/gct_top_tb.sv
module gct_top_tb;
  localparam int LAT = 4;
  localparam logic [11:0] CNT_LO = 12'h100, CNT_HI = 12'h104, CNT_WS = 12'h110;
  localparam logic [11:0] CMP_LO = 12'h200, CMP_HI = 12'h204, INCR = 12'h208;
  localparam logic [11:0] CTRL = 12'h240, ISTAT = 12'h244, IEN = 12'h248, WS = 12'h24C;
  localparam logic [31:0] RUN = 32'h100, AUTO = 32'h2, CEN = 32'h1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gct_top #(.APPLY_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] exp_ctrl(input logic [31:0] d);
    return d & 32'h0000_0103;
  endfunction

  function automatic logic [31:0] exp_auto_cmp(input logic [31:0] first, input logic [31:0] step,
                                               input logic [31:0] c);
    if (c < first) return first;
    return first + step * ((c - first) / step + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    issue_wr(a, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2, c, m;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(CNT_LO, v); check("R1 reset count stopped", v, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);

    // R2 / R5 directed loads and readback, counter stopped
    wr(CNT_LO, 32'hDEAD_BEEF); wr(CNT_HI, 32'h0000_0012);
    rd(CNT_LO, v); check("R2 low word load", v, 32'hDEAD_BEEF);
    rd(CNT_HI, v); check("R2 high word load", v, 32'h0000_0012);
    repeat (10) @(negedge clk);
    rd(CNT_LO, v); check("R1 hold while stopped", v, 32'hDEAD_BEEF);
    rd(CNT_WS, v); check("R4 counter flags set", v, 32'h3);
    wr(CNT_WS, 32'h1);
    rd(CNT_WS, v); check("R4 counter flag partial clear", v, 32'h2);
    wr(CNT_WS, 32'h2);
    rd(CNT_WS, v); check("R4 counter flag cleared", v, 32'h0);

    // R3 / R4 apply latency seen through the write-applied flag
    wr(WS, 32'h0001_0007);
    issue_wr(INCR, 32'h0000_0030);
    rd(WS, v); check("R3 not applied early", v, 32'h0);
    rd(INCR, v); check("R3 value not applied early", v, 32'h0);
    repeat (LAT) @(negedge clk);
    rd(WS, v); check("R4 incr flag", v, 32'h4);
    rd(INCR, v); check("R3 value applied", v, 32'h30);
    wr(WS, 32'h0);
    rd(WS, v); check("R4 write 0 keeps flag", v, 32'h4);
    wr(WS, 32'h4);
    rd(WS, v); check("R4 incr flag cleared", v, 32'h0);

    // R5 random register readback
    for (int i = 0; i < 12; i++) begin
      logic [31:0] d;
      logic [11:0] a;
      d = $urandom;
      case ($urandom % 3)
        0: a = CMP_LO;
        1: a = CMP_HI;
        default: a = INCR;
      endcase
      wr(a, d);
      rd(a, v); check("R5 random readback", v, d);
    end
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = $urandom & ~32'h101;
      wr(CTRL, d);
      rd(CTRL, v); check("R5 control readback", v, exp_ctrl(d));
    end
    rd(WS, v); check("R4 all global flags", v, 32'h0001_0007);
    wr(WS, 32'h0001_0007);
    wr(CTRL, 32'h0);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] lo, hi;
      lo = $urandom; hi = $urandom;
      wr(CNT_LO, lo); wr(CNT_HI, hi);
      rd(CNT_LO, v); check("R2 random low", v, lo);
      rd(CNT_HI, v); check("R2 random high", v, hi);
    end

    // R1 running step: reads 9 capture edges apart
    wr(CTRL, RUN);
    rd(CNT_LO, v);
    repeat (7) @(negedge clk);
    rd(CNT_LO, v2);
    check("R1 count step per cycle", v2 - v, 32'd9);

    // R2 carry into the high word
    wr(CTRL, 32'h0);
    wr(CNT_LO, 32'hFFFF_FFF0); wr(CNT_HI, 32'h5);
    wr(CTRL, RUN);
    repeat (40) @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CNT_HI, v); check("R2 carry to high", v, 32'h6);

    // R6 / R8 one-shot match
    wr(CNT_LO, 32'd1000); wr(CNT_HI, 32'h0);
    wr(CMP_LO, 32'd1030); wr(CMP_HI, 32'h0);
    wr(IEN, 32'h1);
    wr(CTRL, RUN | CEN);
    rd(ISTAT, v); check("R6 no status before match", v, 32'h0);
    check("R9 irq low before match", {31'b0, irq}, 32'h0);
    repeat (40) @(negedge clk);
    rd(ISTAT, v); check("R6 status after match", v, 32'h1);
    check("R9 irq after match", {31'b0, irq}, 32'h1);
    rd(CMP_LO, v); check("R8 one-shot compare unchanged", v, 32'd1030);
    repeat (10) @(negedge clk);
    rd(ISTAT, v); check("R6 status sticky", v, 32'h1);
    wr(IEN, 32'h0);
    check("R9 irq gated by enable", {31'b0, irq}, 32'h0);
    rd(IEN, v); check("R5 enable readback", v, 32'h0);
    wr(ISTAT, 32'h1);
    rd(ISTAT, v); check("R6 status cleared", v, 32'h0);

    // R7 compare disabled
    wr(CTRL, 32'h0);
    wr(CNT_LO, 32'd100); wr(CNT_HI, 32'h0);
    wr(CMP_LO, 32'd110);
    wr(IEN, 32'h1);
    wr(CTRL, RUN);
    repeat (30) @(negedge clk);
    rd(ISTAT, v); check("R7 no status when disabled", v, 32'h0);
    check("R7 irq low when disabled", {31'b0, irq}, 32'h0);

    // R8 periodic auto-advance
    wr(CTRL, 32'h0);
    wr(CNT_LO, 32'h0); wr(CNT_HI, 32'h0);
    wr(CMP_LO, 32'd20); wr(CMP_HI, 32'h0);
    wr(INCR, 32'd16);
    wr(CTRL, RUN | AUTO | CEN);
    repeat (100) @(negedge clk);
    wr(CTRL, AUTO | CEN);
    repeat (3) @(negedge clk);
    rd(CNT_LO, c);
    rd(CMP_LO, m);
    check("R8 compare advanced by increment", m, exp_auto_cmp(32'd20, 32'd16, c));
    rd(CMP_HI, v); check("R8 compare high", v, 32'h0);
    rd(ISTAT, v); check("R6 periodic status", v, 32'h1);
    check("R9 periodic irq", {31'b0, irq}, 32'h1);
    wr(ISTAT, 32'h1);
    rd(ISTAT, v); check("R6 clear after periodic", v, 32'h0);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule